// File: doc/BRIEF.md
# Consumer Digital Audio Biphase-Mark Transmitter

This block serializes 16-bit stereo PCM onto a single consumer-format digital audio line. Each stereo frame is sent as two 32-slot subframes, left then right. A subframe carries a sync preamble, eight zero auxiliary slots, the sample LSB first, a validity flag, a user bit, a channel-status bit and an even-parity bit. The preamble is sent as raw line cells and the other 28 slots are biphase-mark coded, so the line runs at two cells per slot. One cell is emitted every `CELL_DIV` clocks. At 16.9344 MHz with the default divide of 3 this gives 5.6448 MHz cells, about 177 ns each, and 44.1 kHz frames.

Samples arrive as left/right pairs over a valid/ready stream and wait in a one-entry holding register. At the first cell of every frame the frame register takes the held pair. If no pair is held, the frame carries silence. Back-pressure rule: `s_ready` is high only while the block is enabled, and only when the holding register is empty or the current cycle is the frame-load cycle. A producer holds `s_valid` and the data until a cycle in which both valid and ready are high. Channel status repeats every `CS_FRAMES` frames and holds the copy-permit flag and fixed category bits. User bits repeat every `U_FRAMES` frames. Dropping `en` forces the line low, clears the holding register and rewinds all timing to a block start.

Top module: `spdif_tx`

## Requirements
- R1: One line cell is emitted every `CELL_DIV` clocks. A subframe takes 64 cells and a frame takes 128 cells, left subframe first. After `en` rises, the first cell of a frame appears on `spdif_out` after the `CELL_DIV`-th rising clock edge.
- R2: In slots 4..31, the aux slots 4..11 are zero, slots 12..27 carry the 16-bit sample LSB first (slot 12 = bit 0), and the validity slot 28 is always 0.
- R3: Slots 0..3 are eight raw cells. The left subframe of frame 0 of each channel-status block starts with 11101000. Every other left subframe starts with 11100010. Every right subframe starts with 11100100. All cells are listed first to last, and the pattern is inverted when the line level before it is high.
- R4: Each slot 4..31 occupies two cells. The first cell inverts the previous cell, and the second cell inverts the first again only when the slot bit is 1.
- R5: Parity slot 31 makes the count of ones over slots 4..31 even. So the last cell of a subframe equals the line level that came before its preamble.
- R6: Channel status (slot 30) is the same in both subframes and is indexed by frame number n within the `CS_FRAMES` block. At n = 2 it carries `copy_ok` as sampled at the block's first frame load. At n = 8..15 it carries bit n-8 of `CAT_CODE`. It is 0 everywhere else.
- R7: User bit (slot 29), with n the frame number within the `U_FRAMES` block, is 1 only in the left subframe and only when n mod 6 = 0 and n >= 12.
- R8: While `en` is low, `spdif_out` is low from the next clock edge. On re-enable, frame 0 begins both the channel-status and user blocks.
- R9: Accepted pairs are sent in order, one per frame. A frame whose load finds the holding register empty sends zero audio. `s_ready` is low whenever `en` is low.
- R10: In the frame-load cycle `s_ready` is high even with a held pair. A pair accepted in that cycle is sent in the following frame, never the one being loaded.
- R11: After reset `spdif_out` and `s_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, nominally 16.9344 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Transmit enable; low forces idle-low line and rewinds timing |
| copy_ok | input | 1 | Copy-permit flag, sampled at each channel-status block start |
| s_valid | input | 1 | Stereo sample pair valid |
| s_ready | output | 1 | Block accepts a pair this cycle |
| s_left | input | 16 | Left sample, two's complement |
| s_right | input | 16 | Right sample, two's complement |
| spdif_out | output | 1 | Biphase-mark coded line |

## Verification
Two events can land in the same clock: the frame register loading from the holding register, and a new pair being written into that holding register. The bench provokes this in two ways. A continuous producer keeps the register full, so every acceptance after the first falls in a load cycle. A single pair is also offered in exactly the cycle before a frame's first cell while the register is empty. The result is judged by decoding the line: the loading frame must carry silence or the old pair, and the new pair must appear one frame later. Copy-permit changes in the middle of a block are judged by whether the change reaches the channel-status slot only in the next block.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

  localparam int AUDIO_W   = 16;
  localparam int SLOT_N    = 32;
  localparam int CELL_N    = 2 * SLOT_N;
  localparam int CODED_N   = SLOT_N - 4;
  localparam int AUDIO_LO  = 12;

  typedef enum logic [1:0] {
    SYNC_BLOCK = 2'd0,
    SYNC_LEFT  = 2'd1,
    SYNC_RIGHT = 2'd2
  } sync_kind_t;

  // Eight raw cells, first cell in bit 7, for a line resting low.
  function automatic logic [7:0] sync_cells(input sync_kind_t k);
    case (k)
      SYNC_BLOCK: sync_cells = 8'b1110_1000;
      SYNC_LEFT:  sync_cells = 8'b1110_0010;
      default:    sync_cells = 8'b1110_0100;
    endcase
  endfunction

endpackage

// File: rtl/spdif_frame_timer.sv
module spdif_frame_timer #(
  parameter int CELL_DIV  = 3,
  parameter int CS_FRAMES = 192,
  parameter int U_FRAMES  = 588,
  localparam int CS_W = $clog2(CS_FRAMES),
  localparam int U_W  = $clog2(U_FRAMES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  output logic            cell_en,
  output logic [5:0]      cell_idx,
  output logic            chan,
  output logic [CS_W-1:0] cs_idx,
  output logic [U_W-1:0]  u_idx,
  output logic            frame_load
);

  logic frame_end;

  generate
    if (CELL_DIV > 1) begin : g_div
      localparam int DIV_W = $clog2(CELL_DIV);
      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               div_q <= '0;
        else if (!run)                            div_q <= '0;
        else if (div_q == DIV_W'(CELL_DIV - 1))   div_q <= '0;
        else                                      div_q <= div_q + 1'b1;
      end

      assign cell_en = run && (div_q == DIV_W'(CELL_DIV - 1));

      AST_CELL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        cell_en |=> !cell_en); // R1
    end else begin : g_nodiv
      assign cell_en = run;
    end
  endgenerate

  assign frame_end  = cell_en && (cell_idx == 6'd63) && chan;
  assign frame_load = cell_en && (cell_idx == 6'd0) && !chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_idx <= '0;
      chan     <= 1'b0;
      cs_idx   <= '0;
      u_idx    <= '0;
    end else if (!run) begin
      cell_idx <= '0;
      chan     <= 1'b0;
      cs_idx   <= '0;
      u_idx    <= '0;
    end else if (cell_en) begin
      cell_idx <= cell_idx + 1'b1;
      if (cell_idx == 6'd63) chan <= ~chan;
      if (frame_end) begin
        cs_idx <= (cs_idx == CS_W'(CS_FRAMES - 1)) ? '0 : cs_idx + 1'b1;
        u_idx  <= (u_idx == U_W'(U_FRAMES - 1))    ? '0 : u_idx + 1'b1;
      end
    end
  end

  AST_CS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && frame_end && cs_idx == CS_W'(CS_FRAMES - 1)) |=> (cs_idx == '0)); // R6
  AST_U_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    u_idx < U_W'(U_FRAMES)); // R7

endmodule

// File: rtl/spdif_subframe_builder.sv
module spdif_subframe_builder
  import spdif_tx_pkg::*;
#(
  parameter int       CS_FRAMES = 192,
  parameter int       U_FRAMES  = 588,
  parameter bit [7:0] CAT_CODE  = 8'h82,
  localparam int CS_W = $clog2(CS_FRAMES),
  localparam int U_W  = $clog2(U_FRAMES)
) (
  input  logic               chan,
  input  logic [CS_W-1:0]    cs_idx,
  input  logic [U_W-1:0]     u_idx,
  input  logic               copy_q,
  input  logic [AUDIO_W-1:0] left_q,
  input  logic [AUDIO_W-1:0] right_q,
  output sync_kind_t         sync_kind,
  output logic [CODED_N-1:0] coded
);

  logic [AUDIO_W-1:0] audio;
  logic               u_bit;
  logic               c_bit;
  logic [CODED_N-2:0] body;

  always_comb begin
    audio = chan ? right_q : left_q;

    if (chan)                 sync_kind = SYNC_RIGHT;
    else if (cs_idx == '0)    sync_kind = SYNC_BLOCK;
    else                      sync_kind = SYNC_LEFT;

    u_bit = !chan && ((u_idx % U_W'(6)) == '0) && (u_idx >= U_W'(12));

    if (cs_idx == CS_W'(2))
      c_bit = copy_q;
    else if (cs_idx >= CS_W'(8) && cs_idx <= CS_W'(15))
      c_bit = CAT_CODE[cs_idx[2:0]];
    else
      c_bit = 1'b0;

    // body bit k is slot k+4; slot 31 (parity) is appended below
    body = '0;
    body[AUDIO_LO-4 +: AUDIO_W] = audio;
    body[24] = 1'b0;
    body[25] = u_bit;
    body[26] = c_bit;
    coded = {^body, body};
  end

endmodule

// File: rtl/spdif_bmc_encoder.sv
module spdif_bmc_encoder
  import spdif_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               cell_en,
  input  logic [5:0]         cell_idx,
  input  sync_kind_t         sync_kind,
  input  logic [CODED_N-1:0] coded,
  output logic               line
);

  logic       line_q;
  logic       lvl_q;
  logic       lvl_now;
  logic [7:0] pat;
  logic [4:0] slot_off;
  logic       slot_bit;
  logic       nxt;

  always_comb begin
    pat      = sync_cells(sync_kind);
    lvl_now  = (cell_idx == 6'd0) ? line_q : lvl_q;
    slot_off = cell_idx[5:1] - 5'd4;
    slot_bit = coded[slot_off];
    if (cell_idx < 6'd8)
      nxt = pat[3'd7 - cell_idx[2:0]] ^ lvl_now;
    else if (!cell_idx[0])
      nxt = ~line_q;
    else
      nxt = line_q ^ slot_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else if (!run) begin
      line_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else if (cell_en) begin
      line_q <= nxt;
      if (cell_idx == 6'd0) lvl_q <= line_q;
    end
  end

  assign line = line_q;

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !line_q); // R8
  AST_CELL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cell_en && cell_idx >= 6'd8 && !cell_idx[0]) |=> (line_q != $past(line_q))); // R4
  AST_SUBFRAME_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cell_en && cell_idx == 6'd63) |=> (line_q == lvl_q)); // R5

endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
  import spdif_tx_pkg::*;
#(
  parameter int       CELL_DIV  = 3,
  parameter int       CS_FRAMES = 192,
  parameter int       U_FRAMES  = 588,
  parameter bit [7:0] CAT_CODE  = 8'h82
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        copy_ok,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [15:0] s_left,
  input  logic [15:0] s_right,
  output logic        spdif_out
);

  localparam int CS_W = $clog2(CS_FRAMES);
  localparam int U_W  = $clog2(U_FRAMES);

  logic               cell_en;
  logic [5:0]         cell_idx;
  logic               chan;
  logic [CS_W-1:0]    cs_idx;
  logic [U_W-1:0]     u_idx;
  logic               frame_load;
  logic               take;

  logic               hold_full;
  logic [AUDIO_W-1:0] hold_l, hold_r;
  logic [AUDIO_W-1:0] frame_l, frame_r;
  logic               copy_q;

  sync_kind_t         sync_kind;
  logic [CODED_N-1:0] coded;

  spdif_frame_timer #(
    .CELL_DIV (CELL_DIV),
    .CS_FRAMES(CS_FRAMES),
    .U_FRAMES (U_FRAMES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (en),
    .cell_en   (cell_en),
    .cell_idx  (cell_idx),
    .chan      (chan),
    .cs_idx    (cs_idx),
    .u_idx     (u_idx),
    .frame_load(frame_load)
  );

  assign s_ready = en && (!hold_full || frame_load);
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_l    <= '0;
      hold_r    <= '0;
      frame_l   <= '0;
      frame_r   <= '0;
      copy_q    <= 1'b0;
    end else if (!en) begin
      hold_full <= 1'b0;
    end else begin
      if (frame_load) begin
        frame_l <= hold_full ? hold_l : '0;
        frame_r <= hold_full ? hold_r : '0;
        if (cs_idx == '0) copy_q <= copy_ok;
      end
      if (take) begin
        hold_l    <= s_left;
        hold_r    <= s_right;
        hold_full <= 1'b1;
      end else if (frame_load) begin
        hold_full <= 1'b0;
      end
    end
  end

  spdif_subframe_builder #(
    .CS_FRAMES(CS_FRAMES),
    .U_FRAMES (U_FRAMES),
    .CAT_CODE (CAT_CODE)
  ) u_build (
    .chan     (chan),
    .cs_idx   (cs_idx),
    .u_idx    (u_idx),
    .copy_q   (copy_q),
    .left_q   (frame_l),
    .right_q  (frame_r),
    .sync_kind(sync_kind),
    .coded    (coded)
  );

  spdif_bmc_encoder u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (en),
    .cell_en  (cell_en),
    .cell_idx (cell_idx),
    .sync_kind(sync_kind),
    .coded    (coded),
    .line     (spdif_out)
  );

  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_load && !hold_full) |=> (frame_l == '0 && frame_r == '0)); // R9
  AST_LOAD_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_load && !s_valid) |=> !hold_full); // R10
  AST_COPY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(frame_load && cs_idx == '0)) |=> $stable(copy_q)); // R6

endmodule

// File: tb/spdif_tx_bench.sv
module spdif_tx_bench;

  localparam int DIV       = 2;
  localparam int CS_FRAMES = 192;
  localparam int U_FRAMES  = 588;
  localparam bit [7:0] CAT = 8'h82;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        copy_ok = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_left = '0;
  logic [15:0] s_right = '0;
  logic        spdif_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int   cur_frame = -1;
  event frame_ev;
  bit   exp_cp [0:3];
  logic [15:0] got_l [0:599];
  logic [15:0] got_r [0:599];

  always #10 clk = ~clk;

  spdif_tx #(
    .CELL_DIV (DIV),
    .CS_FRAMES(CS_FRAMES),
    .U_FRAMES (U_FRAMES),
    .CAT_CODE (CAT)
  ) u_spdif_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .copy_ok  (copy_ok),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_left   (s_left),
    .s_right  (s_right),
    .spdif_out(spdif_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] smp_l(input int k);
    smp_l = 16'(k * 16'h02F1) ^ 16'hA5C3;
  endfunction
  function automatic logic [15:0] smp_r(input int k);
    smp_r = ~(16'(k * 16'h01D7) ^ 16'h3C5A);
  endfunction

  // Called at a negedge; returns at a negedge with s_valid still high.
  task automatic push(input logic [15:0] l, input logic [15:0] r);
    s_valid = 1'b1;
    s_left  = l;
    s_right = r;
    #1;
    while (!s_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  // Starts at the negedge where en was raised; decodes nfr frames.
  task automatic monitor_frames(input int nfr);
    logic [63:0] c;
    logic [31:0] b;
    logic [7:0]  pat, seen;
    logic        lv, tog_ok, ub, cb;
    int          n;
    @(negedge clk);
    check(spdif_out == 1'b0, "R1", "line before first cell", spdif_out, 0);
    @(negedge clk);
    check(spdif_out == 1'b1, "R1", "first cell after CELL_DIV edges", spdif_out, 1);
    lv = 1'b0;
    for (int fr = 0; fr < nfr; fr++) begin
      for (int ch = 0; ch < 2; ch++) begin
        for (int i = 0; i < 64; i++) begin
          if (!(fr == 0 && ch == 0 && i == 0)) repeat (DIV) @(negedge clk);
          if (ch == 0 && i == 0) begin
            cur_frame = fr;
            ->frame_ev;
          end
          c[i] = spdif_out;
        end
        if (ch == 1)                     pat = 8'b1110_0100;
        else if (fr % CS_FRAMES == 0)    pat = 8'b1110_1000;
        else                             pat = 8'b1110_0010;
        if (lv) pat = ~pat;
        for (int j = 0; j < 8; j++) seen[7-j] = c[j];
        check(seen == pat, "R3", $sformatf("preamble fr%0d ch%0d", fr, ch), seen, pat);
        tog_ok = 1'b1;
        b = '0;
        for (int s = 4; s < 32; s++) begin
          if (c[2*s] == c[2*s-1]) tog_ok = 1'b0;
          b[s] = c[2*s] ^ c[2*s+1];
        end
        check(tog_ok, "R4", $sformatf("cell-boundary toggles fr%0d ch%0d", fr, ch), 0, 1);
        check(b[11:4] == 8'h00, "R2", "aux slots", b[11:4], 0);
        check(b[28] == 1'b0, "R2", "validity slot", b[28], 0);
        check((^b[31:4]) == 1'b0, "R5", $sformatf("even parity fr%0d ch%0d", fr, ch), b[31:4], 0);
        check(c[63] == lv, "R5", "subframe end level", c[63], lv);
        n  = fr % U_FRAMES;
        ub = (ch == 0) && (n % 6 == 0) && (n >= 12);
        check(b[29] == ub, "R7", $sformatf("user bit fr%0d ch%0d", fr, ch), b[29], ub);
        n = fr % CS_FRAMES;
        if (n == 2)                  cb = exp_cp[fr / CS_FRAMES];
        else if (n >= 8 && n <= 15)  cb = CAT[n-8];
        else                         cb = 1'b0;
        check(b[30] == cb, "R6", $sformatf("status bit fr%0d ch%0d", fr, ch), b[30], cb);
        if (ch == 0) got_l[fr] = b[27:12];
        else         got_r[fr] = b[27:12];
        lv = c[63];
      end
    end
  endtask

  task automatic t_reset;
    #1;
    check(spdif_out == 1'b0, "R11", "line in reset", spdif_out, 0);
    check(s_ready == 1'b0, "R11", "ready in reset", s_ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(spdif_out == 1'b0 && s_ready == 1'b0, "R11", "after reset release", {spdif_out, s_ready}, 0);
  endtask

  task automatic t_disabled;
    bit bad = 1'b0;
    s_valid = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (s_ready || spdif_out) bad = 1'b1;
    end
    s_valid = 1'b0;
    check(!bad, "R9", "ready and line low while disabled (R8)", bad, 0);
  endtask

  task automatic t_main;
    localparam int NF = 590;
    exp_cp[0] = 1'b1; exp_cp[1] = 1'b0; exp_cp[2] = 1'b1; exp_cp[3] = 1'b1;
    @(negedge clk);
    copy_ok = 1'b1;
    en = 1'b1;
    fork
      monitor_frames(NF);
      begin
        for (int k = 0; k < NF; k++) push(smp_l(k), smp_r(k));
        s_valid = 1'b0;
      end
      begin
        do @(frame_ev); while (cur_frame != 1);
        copy_ok = 1'b0;
        do @(frame_ev); while (cur_frame != 200);
        copy_ok = 1'b1;
      end
    join
    for (int k = 0; k < NF; k++) begin
      check(got_l[k] == smp_l(k), "R9", $sformatf("left sample frame %0d", k), got_l[k], smp_l(k));
      check(got_r[k] == smp_r(k), "R2", $sformatf("right sample frame %0d", k), got_r[k], smp_r(k));
    end
  endtask

  task automatic t_restart;
    localparam int NF = 8;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(spdif_out == 1'b0, "R8", "line low one edge after disable", spdif_out, 0);
    check(s_ready == 1'b0, "R9", "ready low when disabled", s_ready, 0);
    repeat (20) @(negedge clk);
    exp_cp[0] = 1'b0;
    copy_ok = 1'b0;
    en = 1'b1;
    fork
      monitor_frames(NF);
      begin
        push(16'h1111, 16'h2222);
        push(16'h3333, 16'h4444);
        push(16'h5555, 16'h6666);
        s_valid = 1'b0;
        do @(frame_ev); while (cur_frame != 4);
        repeat (128 * DIV - 1) @(negedge clk);
        s_valid = 1'b1;
        s_left  = 16'h8001;
        s_right = 16'h7FFE;
        #1;
        check(s_ready == 1'b1, "R10", "ready in load cycle", s_ready, 1);
        @(posedge clk);
        @(negedge clk);
        s_valid = 1'b0;
      end
    join
    check(got_l[0] == 16'h1111 && got_r[0] == 16'h2222, "R9", "restart frame 0", got_l[0], 16'h1111);
    check(got_l[1] == 16'h3333, "R9", "restart frame 1", got_l[1], 16'h3333);
    check(got_l[2] == 16'h5555 && got_r[2] == 16'h6666, "R9", "restart frame 2", got_r[2], 16'h6666);
    check(got_l[3] == 16'h0 && got_r[4] == 16'h0, "R9", "underrun frames silent", got_l[3], 0);
    check(got_l[5] == 16'h0 && got_r[5] == 16'h0, "R10", "loading frame unaffected", got_l[5], 0);
    check(got_l[6] == 16'h8001 && got_r[6] == 16'h7FFE, "R10", "pair lands next frame", got_l[6], 16'h8001);
    check(got_l[7] == 16'h0, "R10", "single pair sent once", got_l[7], 0);
    @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_disabled();
    t_main();
    t_restart();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule